// File: doc/BRIEF.md
# Four-Function Arithmetic Logic Unit with Condition Flags

This block is a purely combinational arithmetic logic unit. It takes two operand words and a 2-bit function code. From them it produces a result word and three condition flags: signed overflow, zero and carry/borrow. The unit computes a sum, a difference, a bitwise AND or a bitwise XOR. Its outputs settle from its inputs alone: there is no clock, no storage and no flag register inside it.

An execute stage places this block between its operand muxes and whatever captures the condition codes. Every operation drives all three flags. For the two logic functions, the overflow and carry flags are held at 0. The operand width is a parameter, 64 bits by default.

Top module: `quad_alu`

## Requirements
- R1: With function code 0 (add), the result is (X + Y) modulo 2^W.
- R2: With function code 1 (subtract), the result is (X - Y) modulo 2^W.
- R3: With function code 2 (and), the result is the bitwise AND of X and Y.
- R4: With function code 3 (xor), the result is the bitwise XOR of X and Y.
- R5: The zero flag is 1 exactly when every bit of the result is 0, for every function code.
- R6: For add, the overflow flag is 1 exactly when X and Y share a sign bit (bit W-1) and the result's sign bit differs from it.
- R7: For subtract, the overflow flag is 1 exactly when X and Y have different sign bits and the result's sign bit differs from that of X.
- R8: For add, the carry flag equals the carry out of bit W-1, that is, X + Y >= 2^W as unsigned numbers.
- R9: For subtract, the carry flag is the borrow: 1 exactly when X < Y as unsigned numbers.
- R10: For function codes 2 and 3, the overflow and carry flags are both 0.
- R11: All outputs follow changes on the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | W | First operand X |
| opnd_y | input | W | Second operand Y |
| func_sel | input | 2 | Function code: 0 add, 1 subtract, 2 and, 3 xor |
| result | output | W | Result word |
| flag_ovf | output | 1 | Signed overflow flag |
| flag_zero | output | 1 | Zero flag |
| flag_carry | output | 1 | Carry out (add) or borrow (subtract) |

## Verification
The bound checks rely on the inputs being free of unknown bits, and they hold back while any input carries X or Z. Because the unit has no state, the checks also assume that all inputs are settled whenever the outputs are read. The bench therefore changes all operands and the function code together and reads the outputs a few nanoseconds later. One instance at 6 bits is swept through every operand pair under every function code. A 64-bit instance receives sign-boundary, carry-boundary and random operands.

// File: rtl/quad_alu_pkg.sv
package quad_alu_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic carry;
  } alu_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         sovf
);
  localparam int MSB = W - 1;

  // one adder serves both add and subtract: a + ~b + 1 forms a - b
  function automatic logic [W:0] wide_add(input logic [W-1:0] p,
                                          input logic [W-1:0] q,
                                          input logic         cin);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, cin};
  endfunction

  logic [W-1:0] b_eff;
  logic [W:0]   total;

  always_comb begin
    b_eff = do_sub ? ~b : b;
    total = wide_add(a, b_eff, do_sub);
    sum   = total[W-1:0];
    cout  = total[W];
    // overflow happens when both addends share a sign and the sum leaves it
    sovf  = (a[MSB] == b_eff[MSB]) && (total[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_w,
  output logic [W-1:0] xor_w
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign and_w[i] = a[i] & b[i];
      assign xor_w[i] = a[i] ^ b[i];
    end
  endgenerate
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import quad_alu_pkg::*;
#(
  parameter int W = 64
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] res,
  input  logic         arith_cout,
  input  logic         arith_ovf,
  output alu_flags_t   flags
);
  always_comb begin
    flags.zero = ~|res;
    unique case (fn)
      FN_ADD: begin flags.ovf = arith_ovf; flags.carry = arith_cout;  end
      FN_SUB: begin flags.ovf = arith_ovf; flags.carry = ~arith_cout; end
      default: begin flags.ovf = 1'b0;     flags.carry = 1'b0;        end
    endcase
  end
endmodule

// File: rtl/quad_alu.sv
module quad_alu
  import quad_alu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] opnd_x,
  input  logic [W-1:0] opnd_y,
  input  logic [1:0]   func_sel,
  output logic [W-1:0] result,
  output logic         flag_ovf,
  output logic         flag_zero,
  output logic         flag_carry
);
  alu_fn_e      fn;
  logic [W-1:0] arith_sum, and_word, xor_word;
  logic         arith_cout, arith_ovf;
  alu_flags_t   flags;

  assign fn = alu_fn_e'(func_sel);

  alu_addsub #(.W(W)) u_addsub (
    .a(opnd_x), .b(opnd_y), .do_sub(fn == FN_SUB),
    .sum(arith_sum), .cout(arith_cout), .sovf(arith_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a(opnd_x), .b(opnd_y), .and_w(and_word), .xor_w(xor_word)
  );

  always_comb begin
    unique case (fn)
      FN_ADD, FN_SUB: result = arith_sum;
      FN_AND:         result = and_word;
      default:        result = xor_word;
    endcase
  end

  alu_flags #(.W(W)) u_flags (
    .fn(fn), .res(result), .arith_cout(arith_cout), .arith_ovf(arith_ovf),
    .flags(flags)
  );

  assign flag_ovf   = flags.ovf;
  assign flag_zero  = flags.zero;
  assign flag_carry = flags.carry;
endmodule

// File: rtl/quad_alu_chk.sv
module quad_alu_chk #(
  parameter int W = 64
) (
  input logic [W-1:0] opnd_x,
  input logic [W-1:0] opnd_y,
  input logic [1:0]   func_sel,
  input logic [W-1:0] result,
  input logic         flag_ovf,
  input logic         flag_zero,
  input logic         flag_carry
);
  logic known;
  assign known = !$isunknown({opnd_x, opnd_y, func_sel});

  always_comb begin
    if (known) begin
      if (func_sel == 2'd0) begin
        assert_add_value_R1: assert (result - opnd_y == opnd_x);
        assert_add_carry_R8: assert (flag_carry == (result < opnd_x));
        if (opnd_x[W-1] == opnd_y[W-1]) begin
          assert_add_overflow_R6: assert (flag_ovf == (result[W-1] != opnd_x[W-1]));
        end else begin
          assert_add_no_overflow_R6: assert (!flag_ovf);
        end
      end
      if (func_sel == 2'd1) begin
        assert_sub_value_R2: assert (result + opnd_y == opnd_x);
        assert_sub_borrow_R9: assert (flag_carry == (opnd_x < opnd_y));
        if (opnd_x[W-1] == opnd_y[W-1]) begin
          assert_sub_no_overflow_R7: assert (!flag_ovf);
        end
      end
      if (func_sel == 2'd2) begin
        assert_and_subset_R3: assert (((result & ~opnd_x) | (result & ~opnd_y)) == '0);
      end
      if (func_sel == 2'd3) begin
        assert_xor_inverse_R4: assert ((result ^ opnd_y) == opnd_x);
        assert_xor_zero_R5: assert (flag_zero == (opnd_x == opnd_y));
      end
      if (func_sel[1]) begin
        assert_logic_flags_clear_R10: assert (!flag_ovf && !flag_carry);
      end
    end
  end
endmodule

bind quad_alu quad_alu_chk #(.W(W)) u_quad_alu_chk (
  .opnd_x(opnd_x), .opnd_y(opnd_y), .func_sel(func_sel), .result(result),
  .flag_ovf(flag_ovf), .flag_zero(flag_zero), .flag_carry(flag_carry)
);

// File: tb/quad_alu_bench.sv
`timescale 1ns/1ps
module quad_alu_bench;
  localparam int WB = 64;
  localparam int WS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [WB-1:0] x_b = '0, y_b = '0, r_b;
  logic [1:0]    f_b = 2'd0;
  logic          of_b, zf_b, cf_b;

  logic [WS-1:0] x_s = '0, y_s = '0, r_s;
  logic [1:0]    f_s = 2'd0;
  logic          of_s, zf_s, cf_s;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  quad_alu #(.W(WB)) u_quad_alu (
    .opnd_x(x_b), .opnd_y(y_b), .func_sel(f_b), .result(r_b),
    .flag_ovf(of_b), .flag_zero(zf_b), .flag_carry(cf_b)
  );

  quad_alu #(.W(WS)) u_quad_alu_small (
    .opnd_x(x_s), .opnd_y(y_s), .func_sel(f_s), .result(r_s),
    .flag_ovf(of_s), .flag_zero(zf_s), .flag_carry(cf_s)
  );

  // arithmetic reference: exact integers, then range tests
  task automatic model(input int w, input logic [63:0] x, input logic [63:0] y,
                       input logic [1:0] f, output logic [63:0] r,
                       output logic o, output logic z, output logic c);
    logic [63:0] mask;
    logic [65:0] ux, uy, ut;
    logic signed [65:0] sx, sy, st, maxv, minv;
    mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    ux = {2'b0, x & mask};
    uy = {2'b0, y & mask};
    sx = $signed(ux);
    sy = $signed(uy);
    if (x[w-1]) sx = sx - (66'sd1 <<< w);
    if (y[w-1]) sy = sy - (66'sd1 <<< w);
    maxv = (66'sd1 <<< (w - 1)) - 66'sd1;
    minv = -(66'sd1 <<< (w - 1));
    o = 1'b0; c = 1'b0;
    case (f)
      2'd0: begin
        ut = ux + uy; r = ut[63:0] & mask; c = ut[w];
        st = sx + sy; o = (st > maxv) || (st < minv);
      end
      2'd1: begin
        ut = ux - uy; r = ut[63:0] & mask; c = (ux < uy);
        st = sx - sy; o = (st > maxv) || (st < minv);
      end
      2'd2: r = (x & y) & mask;
      default: r = (x ^ y) & mask;
    endcase
    z = (r == 64'd0);
  endtask

  function automatic string req_of(input logic [1:0] f, input int which);
    // which: 0 result, 1 ovf, 2 zero, 3 carry
    if (which == 2) return "R5";
    if (which == 0) return (f == 0) ? "R1" : (f == 1) ? "R2" : (f == 2) ? "R3" : "R4";
    if (which == 1) return (f == 0) ? "R6" : (f == 1) ? "R7" : "R10";
    return (f == 0) ? "R8" : (f == 1) ? "R9" : "R10";
  endfunction

  task automatic compare(input int w, input logic [63:0] x, input logic [63:0] y,
                         input logic [1:0] f, input logic [63:0] ar,
                         input logic ao, input logic az, input logic ac);
    logic [63:0] er;
    logic eo, ez, ec;
    model(w, x, y, f, er, eo, ez, ec);
    checks++;
    if (ar !== er || ao !== eo || az !== ez || ac !== ec) begin
      failures++;
      if (ar !== er)
        $display("FAIL %s w=%0d f=%0d x=%h y=%h result actual=%h expected=%h",
                 req_of(f, 0), w, f, x, y, ar, er);
      if (ao !== eo)
        $display("FAIL %s w=%0d f=%0d x=%h y=%h ovf actual=%b expected=%b",
                 req_of(f, 1), w, f, x, y, ao, eo);
      if (az !== ez)
        $display("FAIL %s w=%0d f=%0d x=%h y=%h zero actual=%b expected=%b",
                 req_of(f, 2), w, f, x, y, az, ez);
      if (ac !== ec)
        $display("FAIL %s w=%0d f=%0d x=%h y=%h carry actual=%b expected=%b",
                 req_of(f, 3), w, f, x, y, ac, ec);
    end
  endtask

  // drive 2 ns after an edge, read 3 ns later, well before the next edge (R11)
  task automatic big_vec(input logic [63:0] x, input logic [63:0] y, input logic [1:0] f);
    @(posedge clk);
    #2 x_b = x; y_b = y; f_b = f;
    #3 compare(WB, x, y, f, r_b, of_b, zf_b, cf_b);
  endtask

  task automatic big_all(input logic [63:0] x, input logic [63:0] y);
    for (int f = 0; f < 4; f++) big_vec(x, y, 2'(f));
  endtask

  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: zero operands, add selected -> result 0, zero flag set (R1, R5)
    #3 compare(WB, 64'd0, 64'd0, 2'd0, r_b, of_b, zf_b, cf_b);

    // boundary operands for signed overflow (R6, R7) and carry/borrow (R8, R9)
    big_all(MAXP, 64'd1);
    big_all(MINN, ONES);
    big_all(MINN, MINN);
    big_all(ONES, 64'd1);
    big_all(64'd0, 64'd1);
    big_all(MAXP, MINN);
    big_all(MINN, 64'd1);
    big_all(ONES, ONES);
    big_all(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA);

    // R11: two input changes inside one clock period, each read before an edge
    @(posedge clk);
    #1 x_b = 64'd7; y_b = 64'd7; f_b = 2'd1;
    #2 compare(WB, 64'd7, 64'd7, 2'd1, r_b, of_b, zf_b, cf_b);
    #1 x_b = 64'd3; y_b = 64'd9; f_b = 2'd1;
    #2 compare(WB, 64'd3, 64'd9, 2'd1, r_b, of_b, zf_b, cf_b);

    // random 64-bit operands, all function codes (R1..R10)
    for (int k = 0; k < 1500; k++)
      big_vec({$urandom, $urandom}, {$urandom, $urandom}, 2'(k % 4));

    // exhaustive sweep of the narrow instance: every pair, every code (R1..R10)
    for (int f = 0; f < 4; f++)
      for (int a = 0; a < (1 << WS); a++)
        for (int b = 0; b < (1 << WS); b++) begin
          @(posedge clk);
          #2 x_s = WS'(a); y_s = WS'(b); f_s = 2'(f);
          #3 compare(WS, 64'(a), 64'(b), 2'(f), 64'(r_s), of_s, zf_s, cf_s);
        end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule